// File: doc/BRIEF.md
# Hall-Commutated Three-Phase Bridge Driver

This block turns three digitized Hall sensor levels into the six switch enables of a three-phase bridge. Each phase has its own high-side and low-side enable, so a phase can be pulled high, pulled low, or left floating. The phase that is pulled low is chopped by a PWM whose on-time is set by a duty input. The high-side switch of the active high phase stays on for the whole PWM period.

A digital over-current flag can cut the low-side on-time short. The flag is ignored for the first few cycles of every PWM period, which masks the diode reverse-recovery spike that follows each turn-on. Once the flag trips, the low side stays off until the next period begins.

A start/stop input enables or idles the bridge. A deceleration request, together with a mode select, makes the bridge either coast with every switch open or drive reverse torque. Reverse torque uses the commutation table with the Hall code inverted bit by bit. The speed loop, the ramp generator and the analog comparators sit outside the block.

Top module: `hall_pwm_bridge`

## Requirements
- R1: With `runN`=0, `decelReq`=0 and no current trip, the Hall code {hallIn[2],hallIn[1],hallIn[0]} maps to the phase states below, with bit 0/1/2 of `hiEn`/`loEn` being phase A/B/C, H meaning high side on, L meaning low side on, and M meaning both off:
  - 101 gives A=L, B=H, C=M.
  - 100 gives A=L, B=M, C=H.
  - 110 gives A=M, B=L, C=H.
  - 010 gives A=H, B=L, C=M.
  - 011 gives A=H, B=M, C=L.
  - 001 gives A=M, B=H, C=L.
- R2: Hall codes 000 and 111 turn all six enables off, whatever the mode.
- R3: With `runN`=1 (stop, the idle state of an open input) all six enables are off.
- R4: While the block runs, the high-side enable of the active phase stays at 1 through every cycle of the PWM period.
- R5: In steady drive the low-side enable is on for exactly min(`duty`, PWM_PERIOD) cycles of every PWM_PERIOD cycles. Duty 0 keeps it off, and duty >= PWM_PERIOD keeps it on continuously.
- R6: With `decelReq`=1 and `decelSel`=1 (coast, the idle state of an open select) all six enables are off.
- R7: With `decelReq`=1 and `decelSel`=0 the outputs follow the R1 table applied to the bitwise inverse of the Hall code.
- R8: `overCurrent` has no effect during the first BLANK_CYCLES cycles (default 4) of each PWM period. A flag held high for a whole period leaves exactly min(duty, BLANK_CYCLES+1) low-side on cycles.
- R9: An `overCurrent` flag seen after the blanking window turns the low side off from the next cycle until the end of the PWM period. The next period drives the full duty again.
- R10: All enables are registered, with one clock of latency from the inputs. The high and low enables of one phase are never on together.
- R11: While reset is held, all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hallIn | input | 3 | Digitized Hall sensor levels, bit 2 is the first sensor |
| runN | input | 1 | 0 = run, 1 = stop |
| decelReq | input | 1 | Deceleration requested by the speed loop |
| decelSel | input | 1 | Deceleration mode: 0 = reverse torque, 1 = coast |
| duty | input | $clog2(PWM_PERIOD+1) | Low-side on-cycles per PWM period |
| overCurrent | input | 1 | Current-limit comparator result |
| hiEn | output | 3 | High-side enables, bit 0 = phase A |
| loEn | output | 3 | Low-side enables, bit 0 = phase A |

## Verification
Assertions check every cycle that no phase has both switches on, that at most one high and one low switch are on, and that stop, coast and invalid Hall codes give all-off outputs one cycle later. They also check that a latched current trip keeps the low side off.

The exact commutation pattern for each code, in both the forward and the inverted direction, is shown only by the bench scenarios. The same holds for the number of PWM on-cycles per period, the blanking window, and the release of a trip at the next period boundary.

// File: rtl/hall_drive_pkg.sv
package hall_drive_pkg;

  typedef struct packed {
    logic       driveOn;
    logic [2:0] hiSel;
    logic [2:0] loSel;
  } drive_strobe_t;

  // Phase states per Hall code; bit 0 = phase A.
  function automatic logic [5:0] commutate(input logic [2:0] code);
    logic [2:0] hi;
    logic [2:0] lo;
    unique case (code)
      3'b101:  begin hi = 3'b010; lo = 3'b001; end
      3'b100:  begin hi = 3'b100; lo = 3'b001; end
      3'b110:  begin hi = 3'b100; lo = 3'b010; end
      3'b010:  begin hi = 3'b001; lo = 3'b010; end
      3'b011:  begin hi = 3'b001; lo = 3'b100; end
      3'b001:  begin hi = 3'b010; lo = 3'b100; end
      default: begin hi = 3'b000; lo = 3'b000; end
    endcase
    return {hi, lo};
  endfunction

endpackage

// File: rtl/hall_drive_ctrl.sv
module hall_drive_ctrl
  import hall_drive_pkg::*;
(
  input  logic [2:0]    hallIn,
  input  logic          runN,
  input  logic          decelReq,
  input  logic          decelSel,
  output drive_strobe_t strobes
);

  logic       reverseMode;
  logic       coastMode;
  logic [2:0] effCode;
  logic [5:0] phaseSel;

  always_comb begin
    reverseMode = decelReq && !decelSel;
    coastMode   = decelReq && decelSel;
    effCode     = reverseMode ? ~hallIn : hallIn;
    phaseSel    = commutate(effCode);
    strobes.driveOn = !runN && !coastMode;
    strobes.hiSel   = phaseSel[5:3];
    strobes.loSel   = phaseSel[2:0];
  end

endmodule

// File: rtl/hall_drive_dp.sv
module hall_drive_dp
  import hall_drive_pkg::*;
#(
  parameter int PWM_PERIOD   = 32,
  parameter int BLANK_CYCLES = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  drive_strobe_t                   strobes,
  input  logic [$clog2(PWM_PERIOD+1)-1:0] duty,
  input  logic                            overCurrent,
  output logic [2:0]                      hiEn,
  output logic [2:0]                      loEn
);

  localparam int CNT_W  = $clog2(PWM_PERIOD);
  localparam int DUTY_W = $clog2(PWM_PERIOD + 1);

  logic [CNT_W-1:0] pwmCnt;
  logic             lastTick;
  logic             pastBlank;
  logic             pwmOn;
  logic             tripped;
  logic             lowGate;

  always_comb begin
    lastTick  = (pwmCnt == CNT_W'(PWM_PERIOD - 1));
    pastBlank = (pwmCnt >= CNT_W'(BLANK_CYCLES));
    pwmOn     = (DUTY_W'(pwmCnt) < duty);
    lowGate   = pwmOn && !tripped;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmCnt <= '0;
    end else if (lastTick) begin
      pwmCnt <= '0;
    end else begin
      pwmCnt <= pwmCnt + 1'b1;
    end
  end

  // Trip latch: cleared at the period boundary, set after blanking.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tripped <= 1'b0;
    end else if (lastTick) begin
      tripped <= 1'b0;
    end else if (overCurrent && pastBlank) begin
      tripped <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiEn <= '0;
      loEn <= '0;
    end else begin
      hiEn <= strobes.hiSel & {3{strobes.driveOn}};
      loEn <= strobes.loSel & {3{strobes.driveOn && lowGate}};
    end
  end

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (hiEn & loEn) == 3'b000);  // R10

  AST_ONE_PER_SIDE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hiEn) && $onehot0(loEn));  // R1

  AST_TRIP_BLOCKS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $past(tripped) |-> loEn == 3'b000);  // R9

endmodule

// File: rtl/hall_pwm_bridge.sv
module hall_pwm_bridge
  import hall_drive_pkg::*;
#(
  parameter int PWM_PERIOD   = 32,
  parameter int BLANK_CYCLES = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [2:0]                      hallIn,
  input  logic                            runN,
  input  logic                            decelReq,
  input  logic                            decelSel,
  input  logic [$clog2(PWM_PERIOD+1)-1:0] duty,
  input  logic                            overCurrent,
  output logic [2:0]                      hiEn,
  output logic [2:0]                      loEn
);

  drive_strobe_t strobes;

  hall_drive_ctrl i_ctrl (
    .hallIn   (hallIn),
    .runN     (runN),
    .decelReq (decelReq),
    .decelSel (decelSel),
    .strobes  (strobes)
  );

  hall_drive_dp #(
    .PWM_PERIOD   (PWM_PERIOD),
    .BLANK_CYCLES (BLANK_CYCLES)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .duty        (duty),
    .overCurrent (overCurrent),
    .hiEn        (hiEn),
    .loEn        (loEn)
  );

  AST_STOP_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $past(runN) |-> (hiEn == 3'b000 && loEn == 3'b000));  // R3

  AST_INVALID_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $past(hallIn == 3'b000 || hallIn == 3'b111) |-> (hiEn == 3'b000 && loEn == 3'b000));  // R2

  AST_COAST_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $past(decelReq && decelSel) |-> (hiEn == 3'b000 && loEn == 3'b000));  // R6

endmodule

// File: tb/test_hall_pwm_bridge.sv
module test_hall_pwm_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 32;
  localparam int BLANK      = 4;
  localparam int DW         = $clog2(PERIOD + 1);

  logic          clk = 1'b0;
  logic          rstN;
  logic [2:0]    hallIn;
  logic          runN;
  logic          decelReq;
  logic          decelSel;
  logic [DW-1:0] duty;
  logic          overCurrent;
  logic [2:0]    hiEn;
  logic [2:0]    loEn;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hall_pwm_bridge #(.PWM_PERIOD(PERIOD), .BLANK_CYCLES(BLANK)) i_hall_pwm_bridge (
    .clk(clk), .rstN(rstN), .hallIn(hallIn), .runN(runN), .decelReq(decelReq),
    .decelSel(decelSel), .duty(duty), .overCurrent(overCurrent),
    .hiEn(hiEn), .loEn(loEn)
  );

  // Expected {hi, lo} per code, written from the requirement table.
  function automatic logic [5:0] expTable(input logic [2:0] c);
    case (c)
      3'b101:  return {3'b010, 3'b001};
      3'b100:  return {3'b100, 3'b001};
      3'b110:  return {3'b100, 3'b010};
      3'b010:  return {3'b001, 3'b010};
      3'b011:  return {3'b001, 3'b100};
      3'b001:  return {3'b010, 3'b100};
      default: return 6'b000000;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 1'b0; hallIn = 3'b101; runN = 1'b0; decelReq = 1'b0;
    decelSel = 1'b1; duty = DW'(PERIOD); overCurrent = 1'b0;
    settle();
    check("R11 reset hiEn", hiEn, 0);
    check("R11 reset loEn", loEn, 0);
    rstN = 1'b1;
    settle();
  endtask

  task automatic testForward();
    logic [2:0] seq [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
    runN = 1'b0; decelReq = 1'b0; duty = DW'(PERIOD);
    foreach (seq[i]) begin
      hallIn = seq[i];
      @(negedge clk);  // one register stage: visible now (R10)
      check("R1 forward hiEn", hiEn, expTable(seq[i]) >> 3);
      check("R1 forward loEn", loEn, expTable(seq[i]) & 6'h7);
    end
  endtask

  task automatic testInvalid();
    runN = 1'b0; duty = DW'(PERIOD);
    for (int m = 0; m < 2; m++) begin
      decelReq = (m == 1); decelSel = 1'b0;
      hallIn = 3'b000; settle();
      check("R2 code 000", {hiEn, loEn}, 0);
      hallIn = 3'b111; settle();
      check("R2 code 111", {hiEn, loEn}, 0);
    end
    decelReq = 1'b0;
  endtask

  task automatic testStop();
    hallIn = 3'b011; runN = 1'b1; settle();
    check("R3 stop", {hiEn, loEn}, 0);
    runN = 1'b0; settle();
    check("R3 restart", {hiEn, loEn}, expTable(3'b011));
  endtask

  task automatic testCoast();
    hallIn = 3'b110; decelReq = 1'b1; decelSel = 1'b1; settle();
    check("R6 coast", {hiEn, loEn}, 0);
    decelReq = 1'b0; settle();
  endtask

  task automatic testReverse();
    logic [2:0] seq [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
    decelReq = 1'b1; decelSel = 1'b0; duty = DW'(PERIOD);
    foreach (seq[i]) begin
      hallIn = seq[i]; settle();
      check("R7 reverse", {hiEn, loEn}, expTable(~seq[i]));
    end
    decelReq = 1'b0;
  endtask

  // Count low-side on cycles (phase A) across one full period.
  task automatic countPeriod(input int d, input logic oc, input string req, input int exp);
    int ones = 0;
    int hiBad = 0;
    hallIn = 3'b101; duty = DW'(d); overCurrent = oc;
    repeat (PERIOD + 2) @(negedge clk);
    for (int k = 0; k < PERIOD; k++) begin
      @(negedge clk);
      ones += int'(loEn[0]);
      if (hiEn != 3'b010) hiBad++;
    end
    check(req, ones, exp);
    check("R4 high side steady", hiBad, 0);
    overCurrent = 1'b0;
  endtask

  task automatic testDuty();
    countPeriod(0, 1'b0, "R5 duty 0", 0);
    countPeriod(11, 1'b0, "R5 duty 11", 11);
    countPeriod(PERIOD, 1'b0, "R5 duty full", PERIOD);
  endtask

  task automatic testBlanking();
    countPeriod(3, 1'b1, "R8 trip inside blank ignored", 3);
    countPeriod(20, 1'b1, "R8 trip after blank", BLANK + 1);
  endtask

  task automatic testTripHold();
    int ones;
    hallIn = 3'b101; duty = DW'(20); overCurrent = 1'b0;
    do @(negedge clk); while (loEn[0] != 1'b0);
    do @(negedge clk); while (loEn[0] != 1'b1);
    // Now in counter position 1, loEn shows the position-0 gate.
    ones = 1;
    for (int k = 1; k < PERIOD; k++) begin
      @(negedge clk);
      ones += int'(loEn[0]);
      overCurrent = (k + 1 == 8);
    end
    overCurrent = 1'b0;
    check("R9 one-cycle trip holds low side off", ones, 9);
    ones = 0;
    for (int k = 0; k < PERIOD; k++) begin
      @(negedge clk);
      ones += int'(loEn[0]);
    end
    check("R9 next period full duty", ones, 20);
  endtask

  initial begin
    testReset();
    testForward();
    testInvalid();
    testStop();
    testCoast();
    testReverse();
    testDuty();
    testBlanking();
    testTripHold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule